// File: doc/BRIEF.md
# Serial EEPROM Test Port

This block lets a tester reach an embedded EEPROM core through four digital wires: a test-select line, a serial beat line, a data line and a direction line. While test-select is high (and the digital test-enable qualifier is set), eight beats load a mode code. The code becomes active when test-select drops. With an active code, the direction line chooses how the data line is used. When it is low, the byte at the current address is shifted out one bit per beat. When it is high, bytes are shifted in one bit per beat and handed to the memory's page latch.

An internal byte address counter advances at every byte boundary and wraps. A preset code sends the counter to its top value, so the next transfer lands at address 0. After a write window closes, the data line reports the memory's write cycle: low while busy, then high when done. Three codes steer the write into the memory's whole-array path or its even-page or odd-page fill paths. Two more codes only raise a flag toward the memory: margin read and byte mode.

The serial beat line is sampled on the system clock. Each system cycle in which it is high counts as one beat.

Top module: `eeprom_serial_test_port`

## Requirements
- R1: While `tst` and `test_en` are both high, each beat shifts `io_in` into an 8-bit code register, least significant bit first. The active mode changes only on the cycle after `tst` falls, and the mode flags keep their old values while shifting.
- R2: After reset the mode is 00h (normal operation). Code 00h and any code not listed in R3 leave the port inactive: `io_oe`, `mem_load`, `mem_read` and `mem_clock` stay low.
- R3: Active codes: 01h plain access, 03h whole-array write (`mem_blkmd`), 04h even pages (`mem_blke`), 05h odd pages (`mem_blko`), 06h address preset, 07h margin read (`mem_margin`), 21h byte mode (`mem_bytemd`). Exactly the named flag is high, and 01h and 06h raise none.
- R4: Loading 06h sets the counter to all ones, so the next byte read or written uses address 0. Reset gives the same state.
- R5: With an active code and `rbw` low, `mem_read` is high and `io_out` presents bit k of the byte at the current address before beat k (k = 0 to 7). The address moves on after the eighth beat.
- R6: The address counter wraps from its maximum value to 0.
- R7: With an active code and `rbw` high, `mem_load` is high. Eight beats assemble a byte LSB first. The next cycle carries a one-cycle `mem_clock` pulse with that byte on `mem_wdata` and its address on `mem_addr`.
- R8: A falling `rbw` after at least one complete byte starts a write cycle. `io_oe` is high and `io_out` is low until `mem_busy` has risen and fallen, and then `io_out` is high. A rising `rbw` or `tst` ends this indication.
- R9: A falling `rbw` with no byte loaded starts no write cycle and does not move the address.
- R10: `mem_blkdat` equals bit 0 of the last loaded byte. Two 00h bytes in mode 03h clear the whole array, and two FFh bytes set it.
- R11: `io_oe` is high only for read data and for the busy/ready indication. It is low throughout a write window.
- R12: With `test_en` low, activity on `tst` does not change the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_en | input | 1 | Digital qualifier for mode entry |
| tst | input | 1 | High while a mode code is shifted in |
| rbw | input | 1 | Direction: low reads, high loads; falling edge starts a write |
| ser_clk | input | 1 | Serial beat, one per cycle it is high |
| io_in | input | 1 | Serial data into the port |
| io_out | output | 1 | Serial read data or ready/busy level |
| io_oe | output | 1 | Output enable for the data line |
| mem_addr | output | ADDR_W | Byte address toward the memory |
| mem_wdata | output | BYTE_W | Byte to latch in the page buffer |
| mem_rdata | input | BYTE_W | Byte read from the memory at `mem_addr` |
| mem_busy | input | 1 | Memory write cycle in progress |
| mem_load | output | 1 | Page-load window; falling edge launches programming |
| mem_clock | output | 1 | One-cycle strobe latching `mem_wdata` |
| mem_read | output | 1 | Read enable |
| mem_blkmd | output | 1 | Whole-array write select |
| mem_blkdat | output | 1 | Whole-array data value |
| mem_blke | output | 1 | Even-page fill select |
| mem_blko | output | 1 | Odd-page fill select |
| mem_margin | output | 1 | Margin read select |
| mem_bytemd | output | 1 | Byte-mode select |

## Verification
The hardest states to reach are the even-page and odd-page fills and the whole-array write. Each needs a mode code, a preset, a loaded byte, a full busy/ready handshake and then a sweep of every address to see the result. The bench pairs the port with a small memory model of four-byte pages and a 16-byte array. It chains preset and fill codes so a single loaded byte lands at known offsets of alternate pages, and it reads the whole array back after each fill. The wrap and preset behaviour only show up on the 17th consecutive read. The bench therefore sweeps the full address space and checks one read past it.

// File: rtl/estp_pkg.sv
package estp_pkg;
   localparam int CODE_W = 8;
   localparam logic [CODE_W-1:0] CODE_NORMAL   = 8'h00;
   localparam logic [CODE_W-1:0] CODE_PLAIN    = 8'h01;
   localparam logic [CODE_W-1:0] CODE_BLOCK    = 8'h03;
   localparam logic [CODE_W-1:0] CODE_EVEN     = 8'h04;
   localparam logic [CODE_W-1:0] CODE_ODD      = 8'h05;
   localparam logic [CODE_W-1:0] CODE_PRESET   = 8'h06;
   localparam logic [CODE_W-1:0] CODE_MARGIN   = 8'h07;
   localparam logic [CODE_W-1:0] CODE_BYTEMODE = 8'h21;

   typedef enum logic [1:0] {PH_IDLE, PH_WAIT, PH_BUSY, PH_READY} phase_t;

   typedef struct packed {
      logic active;
      logic blk;
      logic even;
      logic odd;
      logic margin;
      logic bytemd;
   } mode_flags_t;
endpackage

// File: rtl/estp_mode_reg.sv
module estp_mode_reg
   import estp_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        test_en,
   input  logic        tst,
   input  logic        ser_clk,
   input  logic        io_in,
   output mode_flags_t flags,
   output logic        preset,
   output logic        tst_ok
);
   logic [CODE_W-1:0] sh_q;
   logic [CODE_W-1:0] mode_q;
   logic              tst_q;
   logic              take;

   assign tst_ok = tst & test_en;
   assign take   = tst_q & ~tst & test_en;
   assign preset = take & (sh_q == CODE_PRESET);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         mode_q <= CODE_NORMAL;
         tst_q  <= 1'b0;
      end else begin
         tst_q <= tst_ok;
         if (tst_ok && ser_clk)
            sh_q <= {io_in, sh_q[CODE_W-1:1]};
         if (take)
            mode_q <= sh_q;
      end
   end

   always_comb begin
      flags = '0;
      case (mode_q)
         CODE_PLAIN:    flags.active = 1'b1;
         CODE_PRESET:   flags.active = 1'b1;
         CODE_BLOCK:    begin flags.active = 1'b1; flags.blk    = 1'b1; end
         CODE_EVEN:     begin flags.active = 1'b1; flags.even   = 1'b1; end
         CODE_ODD:      begin flags.active = 1'b1; flags.odd    = 1'b1; end
         CODE_MARGIN:   begin flags.active = 1'b1; flags.margin = 1'b1; end
         CODE_BYTEMODE: begin flags.active = 1'b1; flags.bytemd = 1'b1; end
         default:       flags = '0;
      endcase
   end

   assert_mode_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mode_q) |-> ($past(tst_q) && !$past(tst)));

   assert_qualifier_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !test_en |=> $stable(mode_q));
endmodule

// File: rtl/estp_addr_counter.sv
module estp_addr_counter #(
   parameter int ADDR_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              preset,
   input  logic              advance,
   output logic [ADDR_W-1:0] addr_next
);
   localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   logic [ADDR_W-1:0] last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         last_q <= TOP;
      else if (preset)
         last_q <= TOP;
      else if (advance)
         last_q <= last_q + ONE;
   end

   assign addr_next = last_q + ONE;

   assert_preset_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      preset |=> (addr_next == '0));

   assert_wrap_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !preset) |=> (addr_next == $past(addr_next) + ONE));
endmodule

// File: rtl/estp_byte_engine.sv
module estp_byte_engine
   import estp_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              tst_ok,
   input  logic              rbw,
   input  logic              ser_clk,
   input  logic              io_in,
   input  logic [BYTE_W-1:0] mem_rdata,
   input  logic              mem_busy,
   input  logic [ADDR_W-1:0] addr_next,
   output logic              advance,
   output logic              io_out,
   output logic              io_oe,
   output logic              mem_load,
   output logic              mem_read,
   output logic              mem_clock,
   output logic [BYTE_W-1:0] mem_wdata,
   output logic [ADDR_W-1:0] wr_addr
);
   localparam int BIT_W = $clog2(BYTE_W);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

   phase_t            ph_q;
   logic [BIT_W-1:0]  bc_q;
   logic [BYTE_W-1:0] sh_q;
   logic              rbw_q;
   logic              loaded_q;
   logic              clk_q;
   logic [BYTE_W-1:0] wdata_q;
   logic [ADDR_W-1:0] waddr_q;
   logic              port_ok;
   logic              rbw_edge;
   logic              step;
   logic [BYTE_W-1:0] sh_d;

   assign port_ok  = active & ~tst_ok & (ph_q == PH_IDLE);
   assign rbw_edge = rbw ^ rbw_q;
   assign step     = port_ok & ser_clk & ~rbw_edge;
   assign advance  = step & (bc_q == LAST_BIT);
   assign sh_d     = {io_in, sh_q[BYTE_W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q     <= PH_IDLE;
         bc_q     <= '0;
         sh_q     <= '0;
         rbw_q    <= 1'b0;
         loaded_q <= 1'b0;
         clk_q    <= 1'b0;
         wdata_q  <= '0;
         waddr_q  <= '0;
      end else begin
         rbw_q <= rbw;
         clk_q <= 1'b0;
         case (ph_q)
            PH_IDLE: begin
               if (!port_ok) begin
                  bc_q     <= '0;
                  loaded_q <= 1'b0;
               end else if (rbw_edge) begin
                  bc_q     <= '0;
                  loaded_q <= 1'b0;
                  if (!rbw && loaded_q)
                     ph_q <= PH_WAIT;
               end else if (ser_clk) begin
                  bc_q <= bc_q + 1'b1;
                  if (rbw) begin
                     sh_q <= sh_d;
                     if (bc_q == LAST_BIT) begin
                        wdata_q  <= sh_d;
                        waddr_q  <= addr_next;
                        clk_q    <= 1'b1;
                        loaded_q <= 1'b1;
                     end
                  end
               end
            end
            PH_WAIT:  if (mem_busy) ph_q <= PH_BUSY;
            PH_BUSY:  if (!mem_busy) ph_q <= PH_READY;
            default: begin
               bc_q <= '0;
               if ((rbw && !rbw_q) || tst_ok)
                  ph_q <= PH_IDLE;
            end
         endcase
      end
   end

   assign mem_load  = port_ok & rbw;
   assign mem_read  = port_ok & ~rbw;
   assign mem_clock = clk_q;
   assign mem_wdata = wdata_q;
   assign wr_addr   = waddr_q;
   assign io_oe     = (ph_q != PH_IDLE) | mem_read;
   assign io_out    = (ph_q == PH_IDLE) ? mem_rdata[bc_q] : (ph_q == PH_READY);

   assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_clock |=> !mem_clock);

   assert_busy_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(rbw) && loaded_q && port_ok) |=> (io_oe && !io_out));

   assert_no_drive_in_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_load |-> !io_oe);

   assert_empty_close_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(rbw) && !loaded_q && (ph_q == PH_IDLE)) |=> (ph_q == PH_IDLE));
endmodule

// File: rtl/eeprom_serial_test_port.sv
module eeprom_serial_test_port
   import estp_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              test_en,
   input  logic              tst,
   input  logic              rbw,
   input  logic              ser_clk,
   input  logic              io_in,
   output logic              io_out,
   output logic              io_oe,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [BYTE_W-1:0] mem_wdata,
   input  logic [BYTE_W-1:0] mem_rdata,
   input  logic              mem_busy,
   output logic              mem_load,
   output logic              mem_clock,
   output logic              mem_read,
   output logic              mem_blkmd,
   output logic              mem_blkdat,
   output logic              mem_blke,
   output logic              mem_blko,
   output logic              mem_margin,
   output logic              mem_bytemd
);
   localparam int BIT_W = $clog2(BYTE_W);

   generate
      if (ADDR_W < 2 || ADDR_W > 24) begin : g_bad_addr
         $error("ADDR_W must lie in 2..24");
      end
      if (BYTE_W < 2 || (1 << BIT_W) != BYTE_W) begin : g_bad_byte
         $error("BYTE_W must be a power of two of at least 2");
      end
   endgenerate

   mode_flags_t       flags;
   logic              preset;
   logic              tst_ok;
   logic              advance;
   logic [ADDR_W-1:0] addr_next;
   logic [ADDR_W-1:0] wr_addr;

   estp_mode_reg u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .test_en (test_en),
      .tst     (tst),
      .ser_clk (ser_clk),
      .io_in   (io_in),
      .flags   (flags),
      .preset  (preset),
      .tst_ok  (tst_ok)
   );

   estp_addr_counter #(.ADDR_W(ADDR_W)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .preset    (preset),
      .advance   (advance),
      .addr_next (addr_next)
   );

   estp_byte_engine #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (flags.active),
      .tst_ok    (tst_ok),
      .rbw       (rbw),
      .ser_clk   (ser_clk),
      .io_in     (io_in),
      .mem_rdata (mem_rdata),
      .mem_busy  (mem_busy),
      .addr_next (addr_next),
      .advance   (advance),
      .io_out    (io_out),
      .io_oe     (io_oe),
      .mem_load  (mem_load),
      .mem_read  (mem_read),
      .mem_clock (mem_clock),
      .mem_wdata (mem_wdata),
      .wr_addr   (wr_addr)
   );

   assign mem_addr   = mem_clock ? wr_addr : addr_next;
   assign mem_blkdat = mem_wdata[0];
   assign mem_blkmd  = flags.blk;
   assign mem_blke   = flags.even;
   assign mem_blko   = flags.odd;
   assign mem_margin = flags.margin;
   assign mem_bytemd = flags.bytemd;

   assert_inactive_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !flags.active |-> (!mem_load && !mem_read));

   assert_one_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_blkmd, mem_blke, mem_blko, mem_margin, mem_bytemd}));
endmodule

// File: tb/eeprom_serial_test_port_test.sv
module eeprom_serial_test_port_test;
   localparam int AW = 4;
   localparam int DEPTH = 1 << AW;
   localparam int PG = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic test_en = 1'b1;
   logic tst = 1'b0;
   logic rbw = 1'b0;
   logic ser_clk = 1'b0;
   logic io_in = 1'b0;
   logic io_out, io_oe;
   logic [AW-1:0] mem_addr;
   logic [7:0] mem_wdata, mem_rdata;
   logic mem_busy;
   logic mem_load, mem_clock, mem_read;
   logic mem_blkmd, mem_blkdat, mem_blke, mem_blko, mem_margin, mem_bytemd;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit done = 0;

   always #2 clk = ~clk;

   eeprom_serial_test_port #(.ADDR_W(AW), .BYTE_W(8)) uut (
      .clk(clk), .rst_n(rst_n), .test_en(test_en), .tst(tst), .rbw(rbw),
      .ser_clk(ser_clk), .io_in(io_in), .io_out(io_out), .io_oe(io_oe),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_busy(mem_busy), .mem_load(mem_load), .mem_clock(mem_clock),
      .mem_read(mem_read), .mem_blkmd(mem_blkmd), .mem_blkdat(mem_blkdat),
      .mem_blke(mem_blke), .mem_blko(mem_blko), .mem_margin(mem_margin),
      .mem_bytemd(mem_bytemd)
   );

   // memory model: page latch, timed write cycle, whole/even/odd fills
   logic [7:0] mem [DEPTH];
   logic [7:0] pend [DEPTH];
   logic [DEPTH-1:0] pv;
   logic load_d;
   int bcnt;
   int busy_events = 0;
   int strobes = 0;
   logic [AW-1:0] cap_addr;
   logic [7:0] cap_data;

   assign mem_rdata = mem[mem_addr];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin mem[i] <= 8'h00; pend[i] <= 8'h00; end
         pv <= '0; load_d <= 1'b0; mem_busy <= 1'b0; bcnt <= 0;
      end else begin
         load_d <= mem_load;
         if (mem_clock) begin
            pend[mem_addr] <= mem_wdata;
            pv[mem_addr] <= 1'b1;
            strobes <= strobes + 1;
            cap_addr <= mem_addr;
            cap_data <= mem_wdata;
         end
         if (!mem_busy && load_d && !mem_load && pv != '0) begin
            mem_busy <= 1'b1; bcnt <= 6; busy_events <= busy_events + 1;
         end else if (mem_busy) begin
            bcnt <= bcnt - 1;
            if (bcnt == 1) begin
               mem_busy <= 1'b0;
               pv <= '0;
               for (int a = 0; a < DEPTH; a++) begin
                  if (mem_blkmd)
                     mem[a] <= mem_blkdat ? 8'hFF : 8'h00;
                  else if (mem_blke || mem_blko) begin
                     if (pv[a % PG] && (((a / PG) % 2 == 0) ? mem_blke : mem_blko))
                        mem[a] <= pend[a % PG];
                  end else if (pv[a])
                     mem[a] <= pend[a];
               end
            end
         end
      end
   end

   task automatic check(input string req, input longint act, input longint exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic beat(input logic b);
      @(negedge clk); io_in = b; ser_clk = 1'b1;
      @(negedge clk); ser_clk = 1'b0;
   endtask

   task automatic shift_code(input logic [7:0] code);
      @(negedge clk); tst = 1'b1;
      for (int i = 0; i < 8; i++) beat(code[i]);
   endtask

   task automatic set_mode(input logic [7:0] code);
      shift_code(code);
      @(negedge clk); tst = 1'b0;
      @(negedge clk);
   endtask

   task automatic write_byte(input logic [7:0] d);
      if (!rbw) begin @(negedge clk); rbw = 1'b1; end
      for (int i = 0; i < 8; i++) beat(d[i]);
   endtask

   task automatic read_byte(output logic [7:0] v);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk); v[i] = io_out; ser_clk = 1'b1;
         @(negedge clk); ser_clk = 1'b0;
      end
   endtask

   task automatic end_write;
      int n;
      @(negedge clk); rbw = 1'b0;
      @(negedge clk);
      check("R8 busy level", {io_oe, io_out}, 2'b10);
      n = 0;
      while (!(io_out === 1'b1) && n < 60) begin @(negedge clk); n++; end
      check("R8 ready level", {io_oe, io_out, mem_busy}, 3'b110);
      @(negedge clk); rbw = 1'b1;
      @(negedge clk); rbw = 1'b0;
      @(negedge clk);
   endtask

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 29 + 7) & 8'hFF);
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1;
         bad++; total++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      int ev;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 reset state
      check("R2 reset outputs", {io_oe, mem_load, mem_read, mem_clock}, 4'b0000);
      check("R2 reset flags", {mem_blkmd, mem_blke, mem_blko, mem_margin, mem_bytemd}, 5'b0);
      // R2 inactive mode ignores a write window
      write_byte(8'h5A);
      check("R2 no load in normal", mem_load, 1'b0);
      @(negedge clk); rbw = 1'b0;
      @(negedge clk);
      check("R2 no strobe in normal", strobes, 0);
      check("R2 no drive in normal", io_oe, 1'b0);
      // R1 flags hold while shifting, change after tst falls
      shift_code(8'h03);
      check("R1 flags hold while shifting", mem_blkmd, 1'b0);
      @(negedge clk); tst = 1'b0;
      @(negedge clk);
      check("R1 code applied after fall", mem_blkmd, 1'b1);
      // R3 plain code
      set_mode(8'h01);
      check("R3 plain flags", {mem_blkmd, mem_blke, mem_blko, mem_margin, mem_bytemd}, 5'b0);
      check("R5 read enable", {mem_read, io_oe}, 2'b11);
      // R7 byte writes across the full address space
      for (int a = 0; a < DEPTH; a++) begin
         write_byte(pat(a));
         check("R11 no drive in window", {io_oe, mem_load}, 2'b01);
         @(negedge clk);
         check("R7 strobe address", cap_addr, a);
         check("R7 strobe data", cap_data, pat(a));
         check("R7 strobe count", strobes, a + 1);
      end
      ev = busy_events;
      end_write();
      check("R8 one write cycle", busy_events, ev + 1);
      // R9 empty window
      ev = busy_events;
      @(negedge clk); rbw = 1'b1;
      repeat (2) @(negedge clk);
      rbw = 1'b0;
      repeat (10) @(negedge clk);
      check("R9 no write cycle", busy_events, ev);
      // R5 reads and R6 wrap
      for (int a = 0; a < DEPTH; a++) begin
         read_byte(v);
         check("R5 read byte", v, pat(a));
      end
      read_byte(v);
      check("R6 wrap to zero", v, pat(0));
      read_byte(v);
      check("R5 next after wrap", v, pat(1));
      // R4 preset
      set_mode(8'h06);
      check("R3 preset flags", {mem_blkmd, mem_blke, mem_blko, mem_margin, mem_bytemd}, 5'b0);
      read_byte(v);
      check("R4 preset to zero", v, pat(0));
      // R10 whole-array write zeros then ones
      set_mode(8'h03);
      check("R3 block flags", {mem_blkmd, mem_blke, mem_blko, mem_margin, mem_bytemd}, 5'b10000);
      write_byte(8'h00); write_byte(8'h00);
      @(negedge clk);
      check("R10 block data zero", mem_blkdat, 1'b0);
      end_write();
      for (int a = 0; a < DEPTH; a++) begin
         read_byte(v);
         check("R10 array cleared", v, 8'h00);
      end
      write_byte(8'hFF); write_byte(8'hFF);
      @(negedge clk);
      check("R10 block data one", mem_blkdat, 1'b1);
      end_write();
      for (int a = 0; a < DEPTH; a++) begin
         read_byte(v);
         check("R10 array set", v, 8'hFF);
      end
      // R3 even-page fill
      set_mode(8'h06);
      set_mode(8'h04);
      check("R3 even flags", {mem_blkmd, mem_blke, mem_blko, mem_margin, mem_bytemd}, 5'b01000);
      write_byte(8'hA5);
      end_write();
      set_mode(8'h06);
      for (int a = 0; a < DEPTH; a++) begin
         read_byte(v);
         check("R3 even pages filled", v, (a % PG == 0 && (a / PG) % 2 == 0) ? 8'hA5 : 8'hFF);
      end
      // R3 odd-page fill
      set_mode(8'h06);
      set_mode(8'h05);
      check("R3 odd flags", {mem_blkmd, mem_blke, mem_blko, mem_margin, mem_bytemd}, 5'b00100);
      write_byte(8'h3C); write_byte(8'hC3);
      end_write();
      set_mode(8'h06);
      for (int a = 0; a < DEPTH; a++) begin
         logic [7:0] e;
         e = 8'hFF;
         if (a % PG == 0 && (a / PG) % 2 == 0) e = 8'hA5;
         if ((a / PG) % 2 == 1 && a % PG == 0) e = 8'h3C;
         if ((a / PG) % 2 == 1 && a % PG == 1) e = 8'hC3;
         read_byte(v);
         check("R3 odd pages filled", v, e);
      end
      // R3 margin and byte mode
      set_mode(8'h07);
      check("R3 margin flags", {mem_blkmd, mem_blke, mem_blko, mem_margin, mem_bytemd, mem_read}, 6'b000101);
      set_mode(8'h21);
      check("R3 bytemode flags", {mem_blkmd, mem_blke, mem_blko, mem_margin, mem_bytemd, mem_read}, 6'b000011);
      // R2 unknown code is inactive
      set_mode(8'h55);
      check("R2 unknown code inactive", {mem_read, io_oe, mem_blkmd, mem_bytemd}, 4'b0000);
      // R12 qualifier low blocks entry
      set_mode(8'h01);
      test_en = 1'b0;
      set_mode(8'h55);
      check("R12 mode kept without qualifier", mem_read, 1'b1);
      test_en = 1'b1;
      repeat (4) @(negedge clk);
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule